// File: doc/BRIEF.md
# Command-Driven SAR Conversion Sequencer

This block sits between a 16-bit serial command port and a 10-bit successive-approximation analog front end. Each received command word carries an operation code and a 5-bit channel selector. The block can stop everything, run a single conversion, arm a conversion that waits for an external trigger, or do nothing. While a conversion runs, it drives a trial code to an external DAC and reads back a one-bit comparator decision. When the conversion is complete it builds a 16-bit result word for the serial port and signals completion on a flag output and an active-low interrupt output.

A special channel code reads eight digital port bits in place of a conversion. A new conversion request cancels the conversion in progress. A NOP leaves a triggered conversion armed on the same channel, so each new trigger edge repeats the conversion. Operation codes and channel codes that are not defined act as STOP. The completion flag is held back while a serial frame is being received. It is cleared once the frame that carries the result has been shifted out.

Top module: `sar_cmd_seq`

## Requirements
- R1: After reset, endc_o is 0, irq_no is 1, busy_o is 0 and result_o is 16'h0000.
- R2: The operation sits in cmd_word_i[15:13] and the channel in cmd_word_i[12:8]. Operation 001 is a single conversion, 101 a triggered conversion, 100 a NOP and 000 STOP. Bits 7..0 have no effect.
- R3: The conversion resolves bits from MSB to LSB. A trial bit is kept when cmp_i is 1, meaning the input is at or above dac_code_o. The final code is the largest code that the comparator accepts.
- R4: A conversion sets endc_o to 1 and irq_no to 0 within 50 clocks of the command. The result word holds the code in bits 15..6, the channel in bits 5..1 and a 1 in bit 0.
- R5: While endc_o is 0, result_o reads 16'h0000. A frame_done_i pulse while endc_o is 1 returns endc_o to 0 and irq_no to 1.
- R6: A completion that falls while frame_active_i is 1 raises endc_o only after frame_active_i returns to 0.
- R7: A single or triggered conversion command that is accepted during a conversion cancels that conversion. Only the new request completes.
- R8: STOP ends any activity and returns the outputs to the reset state of R1.
- R9: Operation codes 010, 011, 110 and 111, channels 24 to 30, and channel 31 with a triggered conversion all act as STOP.
- R10: A NOP received during a conversion does not change its result or its completion.
- R11: A triggered conversion starts on a rising edge of trig_i, after the input is filtered on tick_i. Following a NOP, each new edge repeats the conversion on the same channel.
- R12: Trigger edges that arrive while a conversion is running start no extra conversion.
- R13: Channel 31 with operation 001 reads port_i within 10 clocks. The result word is {port_i, 8'b0000_0011}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Sampling tick for the trigger filter |
| trig_i | input | 1 | External trigger, idles high |
| cmd_valid_i | input | 1 | Command word is valid this cycle |
| cmd_word_i | input | 16 | Received command word |
| frame_active_i | input | 1 | Serial frame in progress |
| frame_done_i | input | 1 | Last cycle of a serial frame |
| cmp_i | input | 1 | Comparator decision: input is at or above the DAC |
| port_i | input | 8 | Digital port bits for a port read |
| dac_code_o | output | 10 | Trial code to the DAC |
| sample_o | output | 1 | Sample window of the front end |
| busy_o | output | 1 | Conversion or port read in progress |
| endc_o | output | 1 | Completion flag |
| irq_no | output | 1 | Completion interrupt, active low |
| result_o | output | 16 | Result word for the serial port |

## Verification
Two events can fall close together: the end of a conversion and a serial frame in progress, including the last cycle of that frame. The bench starts a conversion and then opens a long NOP frame that covers the point where the conversion ends. It checks that endc_o stays low on every cycle of the frame and rises only after frame_active_i drops, with the result intact. It also checks that a frame ending while endc_o is high clears the flag and does not lose a completion that is still pending.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  typedef enum logic [2:0] {ACT_NONE, ACT_STOP, ACT_CONV, ACT_ARM, ACT_PORT} act_e;
  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_CONV, ST_PORT} seq_st_e;
  typedef enum logic [1:0] {PH_IDLE, PH_SAMPLE, PH_BITS} sar_ph_e;
endpackage

// File: rtl/sar_cmd_decode.sv
module sar_cmd_decode
  import sar_seq_pkg::*;
#(
  parameter int unsigned CH_W     = 5,
  parameter int unsigned NUM_AN   = 24,
  parameter int unsigned PORT_SEL = 31
) (
  input  logic [2:0]      op_i,
  input  logic [CH_W-1:0] chan_i,
  output act_e            act_o
);
  logic an_ok, is_port;

  always_comb begin
    an_ok   = chan_i < CH_W'(NUM_AN);
    is_port = chan_i == CH_W'(PORT_SEL);
    unique case (op_i)
      3'b000:  act_o = ACT_STOP;
      3'b100:  act_o = ACT_NONE;
      3'b001:  act_o = an_ok ? ACT_CONV : (is_port ? ACT_PORT : ACT_STOP);
      3'b101:  act_o = an_ok ? ACT_ARM : ACT_STOP;
      default: act_o = ACT_STOP;
    endcase
  end
endmodule

// File: rtl/sar_trig_filter.sv
module sar_trig_filter (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic trig_i,
  output logic rise_o
);
  logic sync_q, smp_q, filt_q, filt_d_q;

  // idle level is high, so reset state is high: no false edge after reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q   <= 1'b1;
      smp_q    <= 1'b1;
      filt_q   <= 1'b1;
      filt_d_q <= 1'b1;
    end else begin
      sync_q   <= trig_i;
      filt_d_q <= filt_q;
      if (tick_i) begin
        smp_q <= sync_q;
        if (sync_q == smp_q) filt_q <= smp_q;
      end
    end
  end

  assign rise_o = filt_q & ~filt_d_q;
endmodule

// File: rtl/sar_engine.sv
module sar_engine
  import sar_seq_pkg::*;
#(
  parameter int unsigned RES_W      = 10,
  parameter int unsigned SAMPLE_CYC = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             abort_i,
  input  logic             cmp_i,
  output logic [RES_W-1:0] dac_o,
  output logic             sample_o,
  output logic             done_o,
  output logic [RES_W-1:0] code_o
);
  localparam int unsigned CNT_W = $clog2(SAMPLE_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SAMPLE_CYC - 1);
  localparam logic [RES_W-1:0] MSB_MASK = {1'b1, {(RES_W-1){1'b0}}};

  sar_ph_e          ph_q;
  logic [CNT_W-1:0] cnt_q;
  logic [RES_W-1:0] code_q, mask_q;
  logic             done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      code_q <= '0;
      mask_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (abort_i) begin
        ph_q   <= PH_IDLE;
        code_q <= '0;
        mask_q <= '0;
      end else if (start_i) begin
        ph_q   <= PH_SAMPLE;
        cnt_q  <= '0;
        code_q <= '0;
        mask_q <= '0;
      end else begin
        unique case (ph_q)
          PH_SAMPLE: begin
            if (cnt_q == CNT_LAST) begin
              ph_q   <= PH_BITS;
              mask_q <= MSB_MASK;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          PH_BITS: begin
            if (cmp_i) code_q <= code_q | mask_q;
            mask_q <= mask_q >> 1;
            if (mask_q[0]) begin
              ph_q   <= PH_IDLE;
              done_q <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign dac_o    = (ph_q == PH_BITS) ? (code_q | mask_q) : code_q;
  assign sample_o = ph_q == PH_SAMPLE;
  assign done_o   = done_q;
  assign code_o   = code_q;
endmodule

// File: rtl/sar_cmd_seq.sv
module sar_cmd_seq
  import sar_seq_pkg::*;
#(
  parameter int unsigned RES_W      = 10,
  parameter int unsigned CH_W       = 5,
  parameter int unsigned PORT_W     = 8,
  parameter int unsigned NUM_AN     = 24,
  parameter int unsigned PORT_SEL   = 31,
  parameter int unsigned SAMPLE_CYC = 16,
  parameter int unsigned PORT_CYC   = 10
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      tick_i,
  input  logic                      trig_i,
  input  logic                      cmd_valid_i,
  input  logic [15:0]               cmd_word_i,
  input  logic                      frame_active_i,
  input  logic                      frame_done_i,
  input  logic                      cmp_i,
  input  logic [PORT_W-1:0]         port_i,
  output logic [RES_W-1:0]          dac_code_o,
  output logic                      sample_o,
  output logic                      busy_o,
  output logic                      endc_o,
  output logic                      irq_no,
  output logic [RES_W+CH_W:0]       result_o
);
  localparam int unsigned DATA_W = RES_W + CH_W;
  localparam int unsigned PAD_W  = DATA_W - PORT_W;
  localparam int unsigned PCNT_W = $clog2(PORT_CYC + 1);
  localparam logic [PCNT_W-1:0] PCNT_LAST = PCNT_W'(PORT_CYC - 1);

  act_e              act;
  logic [CH_W-1:0]   cmd_chan;
  logic              cmd_hit, trig_rise, trig_start;
  logic              eng_start, eng_abort, eng_done;
  logic [RES_W-1:0]  eng_code;
  logic              port_done, fin;
  logic [DATA_W-1:0] fin_word;
  logic              unused_low;

  seq_st_e           st_q;
  logic              atc_q, endc_q, pend_q;
  logic [CH_W-1:0]   chan_q;
  logic [PCNT_W-1:0] pcnt_q;
  logic [DATA_W-1:0] data_q;

  assign cmd_chan   = cmd_word_i[12:8];
  assign unused_low = ^cmd_word_i[7:0];

  sar_cmd_decode #(.CH_W(CH_W), .NUM_AN(NUM_AN), .PORT_SEL(PORT_SEL)) u_dec (
    .op_i   (cmd_word_i[15:13]),
    .chan_i (cmd_chan),
    .act_o  (act)
  );

  sar_trig_filter u_trig (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .trig_i (trig_i),
    .rise_o (trig_rise)
  );

  // a command in the same cycle wins over a trigger edge
  assign cmd_hit    = cmd_valid_i && (act != ACT_NONE);
  assign trig_start = !cmd_hit && (st_q == ST_WAIT) && trig_rise;
  assign eng_start  = (cmd_hit && act == ACT_CONV) || trig_start;
  assign eng_abort  = cmd_hit && (act != ACT_CONV);

  sar_engine #(.RES_W(RES_W), .SAMPLE_CYC(SAMPLE_CYC)) u_sar (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (eng_start),
    .abort_i  (eng_abort),
    .cmp_i    (cmp_i),
    .dac_o    (dac_code_o),
    .sample_o (sample_o),
    .done_o   (eng_done),
    .code_o   (eng_code)
  );

  assign port_done = (st_q == ST_PORT) && (pcnt_q == PCNT_LAST);
  assign fin       = !cmd_hit && ((st_q == ST_CONV && eng_done) || port_done);
  assign fin_word  = port_done ? {port_i, PAD_W'(1)} : {eng_code, chan_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      atc_q  <= 1'b0;
      endc_q <= 1'b0;
      pend_q <= 1'b0;
      chan_q <= '0;
      pcnt_q <= '0;
      data_q <= '0;
    end else if (cmd_hit) begin
      endc_q <= 1'b0;
      pend_q <= 1'b0;
      pcnt_q <= '0;
      chan_q <= cmd_chan;
      atc_q  <= act == ACT_ARM;
      unique case (act)
        ACT_CONV: st_q <= ST_CONV;
        ACT_ARM:  st_q <= ST_WAIT;
        ACT_PORT: st_q <= ST_PORT;
        default: begin
          st_q   <= ST_IDLE;
          chan_q <= '0;
          data_q <= '0;
        end
      endcase
    end else begin
      if (trig_start) st_q <= ST_CONV;
      if (st_q == ST_PORT) pcnt_q <= pcnt_q + 1'b1;
      if (frame_done_i && endc_q) endc_q <= 1'b0;
      if (fin) begin
        st_q   <= atc_q ? ST_WAIT : ST_IDLE;
        data_q <= fin_word;
        // hold the flag back while a frame is being received
        if (frame_active_i) pend_q <= 1'b1;
        else                endc_q <= 1'b1;
      end else if (pend_q && !frame_active_i) begin
        pend_q <= 1'b0;
        endc_q <= 1'b1;
      end
    end
  end

  assign busy_o   = (st_q == ST_CONV) || (st_q == ST_PORT);
  assign endc_o   = endc_q;
  assign irq_no   = ~endc_q;
  assign result_o = endc_q ? {data_q, 1'b1} : '0;
endmodule

// File: rtl/sar_cmd_seq_chk.sv
module sar_cmd_seq_chk #(
  parameter int unsigned MAX_CONV = 50
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cmd_valid_i,
  input logic [2:0] op_i,
  input logic       frame_active_i,
  input logic       frame_done_i,
  input logic       busy_o,
  input logic       endc_o,
  input logic       flag_i
);
  localparam int unsigned CW = $clog2(MAX_CONV + 2);
  logic [CW-1:0] busy_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) busy_cnt_q <= '0;
    else if (!busy_o || cmd_valid_i) busy_cnt_q <= '0;
    else if (busy_cnt_q <= CW'(MAX_CONV)) busy_cnt_q <= busy_cnt_q + 1'b1;
  end

  // R4
  conv_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_cnt_q <= CW'(MAX_CONV));

  // R4
  rise_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(endc_o) |-> flag_i);

  // R6
  rise_outside_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(endc_o) |-> !frame_active_i);

  // R5
  frame_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_done_i && endc_o) |=> !endc_o);

  // R8
  stop_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && op_i == 3'b000) |=> (!endc_o && !busy_o));
endmodule

bind sar_cmd_seq sar_cmd_seq_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .cmd_valid_i    (cmd_valid_i),
  .op_i           (cmd_word_i[15:13]),
  .frame_active_i (frame_active_i),
  .frame_done_i   (frame_done_i),
  .busy_o         (busy_o),
  .endc_o         (endc_o),
  .flag_i         (result_o[0])
);

// File: tb/sar_cmd_seq_tb.sv
module sar_cmd_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        trig = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [15:0] cmd_word = '0;
  logic        frame_active = 1'b0;
  logic        frame_done = 1'b0;
  logic [7:0]  port = '0;
  logic [9:0]  vin = '0;
  logic [9:0]  dac_code;
  logic        sample, busy, endc, irq_n;
  logic [15:0] result;
  logic        cmp;
  int          checks = 0;
  int          errors = 0;
  bit          finished = 1'b0;

  always #2 clk = ~clk;
  always @(negedge clk) tick <= ~tick;
  assign cmp = vin >= dac_code;

  sar_cmd_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .trig_i(trig),
    .cmd_valid_i(cmd_valid), .cmd_word_i(cmd_word),
    .frame_active_i(frame_active), .frame_done_i(frame_done),
    .cmp_i(cmp), .port_i(port), .dac_code_o(dac_code), .sample_o(sample),
    .busy_o(busy), .endc_o(endc), .irq_no(irq_n), .result_o(result)
  );

  function automatic logic [15:0] mk(input logic [2:0] op, input logic [4:0] ch);
    return {op, ch, 8'h00};
  endfunction

  function automatic logic [15:0] word_of(input logic [9:0] code, input logic [4:0] ch);
    return {code, ch, 1'b1};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_cmd(input logic [15:0] w);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_word  = w;
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_word  = '0;
  endtask

  task automatic wait_endc(input int max, output int n);
    n = 1;
    while (!endc && n < max) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic send_frame(input logic [15:0] w, output logic [15:0] shifted);
    @(negedge clk);
    shifted = result;
    frame_active = 1'b1;
    repeat (15) @(negedge clk);
    frame_done = 1'b1;
    cmd_valid  = 1'b1;
    cmd_word   = w;
    @(negedge clk);
    frame_active = 1'b0;
    frame_done   = 1'b0;
    cmd_valid    = 1'b0;
    cmd_word     = '0;
  endtask

  task automatic t_reset();
    chk("R1 endc", endc, 0);
    chk("R1 irq", irq_n, 1);
    chk("R1 busy", busy, 0);
    chk("R1 result", result, 0);
  endtask

  task automatic t_single();
    int n;
    logic [15:0] sh;
    vin = 10'd617;
    send_cmd(mk(3'b001, 5'd5) | 16'h005A); // R2 low byte ignored
    wait_endc(80, n);
    chk("R4 latency", n <= 50, 1);
    chk("R3 code", result[15:6], 617);
    chk("R4 word", result, word_of(10'd617, 5'd5));
    chk("R4 irq", irq_n, 0);
    send_frame(mk(3'b100, 5'd0), sh);
    chk("R5 shifted", sh, word_of(10'd617, 5'd5));
    chk("R5 endc", endc, 0);
    chk("R5 irq", irq_n, 1);
    chk("R5 result", result, 0);
  endtask

  task automatic t_postpone();
    int early = 0;
    vin = 10'd100;
    send_cmd(mk(3'b001, 5'd3));
    repeat (4) @(negedge clk);
    frame_active = 1'b1;
    for (int i = 0; i < 39; i++) begin
      @(negedge clk);
      if (endc) early++;
    end
    frame_done = 1'b1;
    cmd_valid  = 1'b1;
    cmd_word   = mk(3'b100, 5'd0);
    @(negedge clk);
    if (endc) early++;
    frame_active = 1'b0;
    frame_done   = 1'b0;
    cmd_valid    = 1'b0;
    chk("R6 no flag inside frame", early, 0);
    @(negedge clk);
    chk("R6 flag after frame", endc, 1);
    chk("R6 word", result, word_of(10'd100, 5'd3));
  endtask

  task automatic t_nop();
    int n;
    vin = 10'd333;
    send_cmd(mk(3'b001, 5'd8));
    repeat (6) @(negedge clk);
    send_cmd(mk(3'b100, 5'd20));
    wait_endc(80, n);
    chk("R10 nop no effect", result, word_of(10'd333, 5'd8));
  endtask

  task automatic t_cancel();
    int n;
    vin = 10'd50;
    send_cmd(mk(3'b001, 5'd2));
    repeat (10) @(negedge clk);
    vin = 10'd900;
    send_cmd(mk(3'b001, 5'd9));
    chk("R7 old flag cleared", endc, 0);
    wait_endc(80, n);
    chk("R7 new request", result, word_of(10'd900, 5'd9));
    chk("R7 latency", n <= 50, 1);
  endtask

  task automatic t_stop();
    int n;
    vin = 10'd12;
    send_cmd(mk(3'b001, 5'd4));
    repeat (10) @(negedge clk);
    send_cmd(mk(3'b000, 5'd0));
    repeat (60) @(negedge clk);
    chk("R8 stop mid endc", endc, 0);
    chk("R8 stop mid busy", busy, 0);
    send_cmd(mk(3'b001, 5'd4));
    wait_endc(80, n);
    chk("R8 before stop", endc, 1);
    send_cmd(mk(3'b000, 5'd0));
    chk("R8 stop endc", endc, 0);
    chk("R8 stop irq", irq_n, 1);
    chk("R8 stop result", result, 0);
  endtask

  task automatic t_invalid();
    logic [15:0] bad [7];
    bad[0] = mk(3'b010, 5'd3);
    bad[1] = mk(3'b011, 5'd3);
    bad[2] = mk(3'b110, 5'd3);
    bad[3] = mk(3'b111, 5'd3);
    bad[4] = mk(3'b001, 5'd26);
    bad[5] = mk(3'b101, 5'd31);
    bad[6] = mk(3'b101, 5'd24);
    vin = 10'd700;
    for (int k = 0; k < 7; k++) begin
      send_cmd(mk(3'b001, 5'd1));
      repeat (8) @(negedge clk);
      send_cmd(bad[k]);
      repeat (60) @(negedge clk);
      chk($sformatf("R9 case %0d", k), {busy, endc}, 2'b00);
    end
  endtask

  task automatic pulse_trig();
    trig = 1'b0;
    repeat (10) @(negedge clk);
    trig = 1'b1;
  endtask

  task automatic t_atc();
    int n;
    logic [15:0] sh;
    vin = 10'd444;
    send_cmd(mk(3'b101, 5'd7));
    repeat (60) @(negedge clk);
    chk("R11 armed waits", {busy, endc}, 2'b00);
    pulse_trig();
    wait_endc(100, n);
    chk("R11 first", result, word_of(10'd444, 5'd7));
    send_frame(mk(3'b100, 5'd0), sh);
    chk("R11 cleared", endc, 0);
    vin = 10'd222;
    pulse_trig();
    wait_endc(100, n);
    chk("R11 repeat same channel", result, word_of(10'd222, 5'd7));
  endtask

  task automatic t_ignore();
    int n;
    logic [15:0] sh;
    send_frame(mk(3'b100, 5'd0), sh);
    vin = 10'd901;
    pulse_trig();
    n = 0;
    while (!busy && n < 40) begin
      @(negedge clk);
      n++;
    end
    chk("R12 started", busy, 1);
    trig = 1'b0;
    repeat (8) @(negedge clk);
    trig = 1'b1;
    wait_endc(100, n);
    chk("R12 result", result, word_of(10'd901, 5'd7));
    send_frame(mk(3'b100, 5'd0), sh);
    repeat (60) @(negedge clk);
    chk("R12 no extra conversion", {busy, endc}, 2'b00);
    send_cmd(mk(3'b000, 5'd0));
  endtask

  task automatic t_port();
    int n;
    port = 8'hA5;
    send_cmd(mk(3'b001, 5'd31));
    wait_endc(40, n);
    chk("R13 timing", (n >= 8) && (n <= 12), 1);
    chk("R13 word", result, 16'hA503);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_single();
    t_postpone();
    t_nop();
    t_cancel();
    t_stop();
    t_invalid();
    t_atc();
    t_ignore();
    t_port();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule